// File: doc/BRIEF.md
# Evicted Region Victim Buffer

When a region-granular tag array displaces a region entry, any of that region's blocks still sitting in the data array must be cleared out. This buffer takes the displaced entry whole. It holds only the tracking record: the region tag, one "still cached" flag per block, and the data-array way of each block. It then hands the blocks to the data array one at a time, over as many cycles as the data array needs. Because the buffer absorbs the whole region in one transfer, the cache never has to evict several blocks in the same cycle.

Entries are kept oldest first. Draining is eager: whenever the buffer holds anything, it offers one eviction request. That request always comes from the oldest held region and names that region's lowest-numbered block that is still cached. An acknowledged request clears that block's flag. An entry with no flags left is released, and every younger entry moves one place toward the front.

When every slot is occupied, the accept side drops its ready signal, which stalls the cache. Draining carries on from the oldest entry until a slot opens.

A lookup port searches all held regions by tag at once. It lets the cache spot an access to a region that is still being drained. A cancel port removes a single block's pending eviction, for an access that would rather keep the block than wait for it.

A region tag is expected to be held in at most one entry at a time.

Top module: `region_victim_buf`

## Requirements
- R1: After reset the buffer is empty: `acc_ready` is 1, `evq_valid` is 0 and `probe_hit` is 0.
- R2: A region offered while `acc_valid` and `acc_ready` are both 1 is stored at that clock edge. From the next cycle, a probe with its tag returns `probe_hit`=1 and `probe_vld` equal to the offered flag vector, where bit b is block b.
- R3: `acc_ready` is 0 exactly when all DEPTH slots are occupied. A region offered while `acc_ready` is 0 is not stored, so a later probe of its tag misses.
- R4: `evq_valid` is 1 whenever at least one region is held. The request carries the oldest held region's tag in `evq_tag` and its lowest-numbered block whose flag is still set in `evq_blk`. `evq_way` gives that block's way, taken from bits [b*WAY_W +: WAY_W] of the way vector supplied at accept.
- R5: While `evq_valid` is 1 and `evq_ack` is 0, and no cancel is applied, the request stays unchanged on the next cycle.
- R6: A cycle with `evq_valid` and `evq_ack` both 1 clears exactly the requested block's flag. From the next cycle the probe vector lacks that bit and the request moves to the next remaining block.
- R7: A region whose last flag is cleared is released at that same edge. `acc_ready` rises again if the buffer was full, and the next request comes from the next-oldest region, in the order the regions were accepted.
- R8: A probe whose tag matches no held region returns `probe_hit`=0 and `probe_vld`=0.
- R9: `cancel_valid` clears block `cancel_blk` of the region tagged `cancel_tag`. That block is never requested afterward. A region whose flags are all cancelled is released exactly as in R7.
- R10: A region accepted with an all-zero flag vector takes no slot: its tag misses on a probe, and `evq_valid` and `acc_ready` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A displaced region is offered |
| acc_ready | output | 1 | A free slot exists (deasserted when full) |
| acc_tag | input | TAG_W | Tag of the offered region |
| acc_vld | input | BLK_N | Per-block "still cached" flags of the offered region |
| acc_way | input | BLK_N*WAY_W | Per-block way numbers, block b at [b*WAY_W +: WAY_W] |
| evq_valid | output | 1 | A block eviction request is offered |
| evq_ack | input | 1 | The data array takes the request |
| evq_tag | output | TAG_W | Region tag of the requested block |
| evq_blk | output | BIDX_W | Block index within the region |
| evq_way | output | WAY_W | Way holding the block |
| probe_tag | input | TAG_W | Tag to search for |
| probe_hit | output | 1 | The probed region is held |
| probe_vld | output | BLK_N | Remaining flags of the probed region |
| cancel_valid | input | 1 | Drop one pending block eviction |
| cancel_tag | input | TAG_W | Region of the cancelled block |
| cancel_blk | input | BIDX_W | Index of the cancelled block |

## Verification
A fault in the age order or in the compaction after a release shows up on the very next request: `evq_tag` names a younger region, or repeats one that was already released. A stale or wrongly cleared flag shows within one cycle, either as a repeated or skipped `evq_blk` or as a probe vector that differs from the flags accepted minus those acknowledged and cancelled. An occupancy count that is off by one shows at the fill boundary. There `acc_ready` drops one region early or late, and an offer made while stalled would turn up on a probe.

// File: rtl/rvb_pkg.sv
package rvb_pkg;
    // Default geometry: twelve slots, sixteen blocks per region,
    // sixteen data-array ways, twenty-bit region tags.
    localparam int RVB_DEPTH  = 12;
    localparam int RVB_BLOCKS = 16;
    localparam int RVB_WAY_W  = 4;
    localparam int RVB_TAG_W  = 20;
endpackage

// File: rtl/rvb_first_set.sv
// Lowest-index set bit finder.
module rvb_first_set #(
    parameter int N = 16,
    parameter int W = 4
) (
    input  logic [N-1:0] vec,
    output logic         found,
    output logic [W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = W'(i);
            end
        end
    end
endmodule

// File: rtl/rvb_match.sv
// Parallel tag comparator across all live slots.
module rvb_match #(
    parameter int DEPTH = 12,
    parameter int TAG_W = 20
) (
    input  logic [DEPTH*TAG_W-1:0] tags,
    input  logic [DEPTH-1:0]       live,
    input  logic [TAG_W-1:0]       key,
    output logic [DEPTH-1:0]       hit
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit[g] = live[g] && (tags[g*TAG_W +: TAG_W] == key);
    end
endmodule

// File: rtl/region_victim_buf.sv
module region_victim_buf
    import rvb_pkg::*;
#(
    parameter int DEPTH  = RVB_DEPTH,
    parameter int BLK_N  = RVB_BLOCKS,
    parameter int WAY_W  = RVB_WAY_W,
    parameter int TAG_W  = RVB_TAG_W,
    parameter int BIDX_W = (BLK_N > 1) ? $clog2(BLK_N) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   acc_valid,
    output logic                   acc_ready,
    input  logic [TAG_W-1:0]       acc_tag,
    input  logic [BLK_N-1:0]       acc_vld,
    input  logic [BLK_N*WAY_W-1:0] acc_way,
    output logic                   evq_valid,
    input  logic                   evq_ack,
    output logic [TAG_W-1:0]       evq_tag,
    output logic [BIDX_W-1:0]      evq_blk,
    output logic [WAY_W-1:0]       evq_way,
    input  logic [TAG_W-1:0]       probe_tag,
    output logic                   probe_hit,
    output logic [BLK_N-1:0]       probe_vld,
    input  logic                   cancel_valid,
    input  logic [TAG_W-1:0]       cancel_tag,
    input  logic [BIDX_W-1:0]      cancel_blk
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int VEC_W = BLK_N * WAY_W;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [BLK_N-1:0] vld;
        logic [VEC_W-1:0] way;
    } entry_t;

    typedef struct packed {
        entry_t [DEPTH-1:0] ent;   // slot 0 is the oldest
        logic   [CNT_W-1:0] cnt;
    } state_t;

    state_t state_q, state_d;

    logic [DEPTH-1:0]       live;
    logic [DEPTH*TAG_W-1:0] tag_flat;
    logic [DEPTH-1:0]       probe_hits;
    logic [DEPTH-1:0]       cancel_hits;
    logic                   head_found;
    logic [BIDX_W-1:0]      head_blk;
    logic                   take;
    logic [CNT_W-1:0]       occ_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign live[g]                      = (state_q.cnt > CNT_W'(g));
        assign tag_flat[g*TAG_W +: TAG_W]   = state_q.ent[g].tag;
    end

    assign occ_q = state_q.cnt;

    // Accept side: only a free slot matters, no path from the drain side.
    assign acc_ready = (state_q.cnt != CNT_W'(DEPTH));
    assign take      = acc_valid && acc_ready;

    // Drain side: always the oldest slot, lowest remaining block.
    rvb_first_set #(.N(BLK_N), .W(BIDX_W)) u_head_pick (
        .vec   (state_q.ent[0].vld),
        .found (head_found),
        .idx   (head_blk)
    );

    assign evq_valid = live[0] && head_found;
    assign evq_tag   = state_q.ent[0].tag;
    assign evq_blk   = head_blk;
    assign evq_way   = state_q.ent[0].way[int'(head_blk)*WAY_W +: WAY_W];

    // Probe and cancel searches.
    rvb_match #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_probe_cam (
        .tags (tag_flat),
        .live (live),
        .key  (probe_tag),
        .hit  (probe_hits)
    );

    rvb_match #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_cancel_cam (
        .tags (tag_flat),
        .live (live),
        .key  (cancel_tag),
        .hit  (cancel_hits)
    );

    always_comb begin
        probe_vld = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (probe_hits[i]) probe_vld = probe_vld | state_q.ent[i].vld;
        end
    end
    assign probe_hit = |probe_hits;

    // Next state: clear cancelled and acknowledged flags, squeeze out
    // empty slots keeping age order, then append the new arrival.
    always_comb begin
        entry_t [DEPTH-1:0] work;
        entry_t             fresh;
        int                 k;

        work = state_q.ent;
        for (int i = 0; i < DEPTH; i++) begin
            if (cancel_valid && cancel_hits[i]) work[i].vld[cancel_blk] = 1'b0;
        end
        if (evq_valid && evq_ack) work[0].vld[head_blk] = 1'b0;

        fresh.tag = acc_tag;
        fresh.vld = acc_vld;
        fresh.way = acc_way;

        state_d.ent = '0;
        k = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (live[i] && (|work[i].vld)) begin
                state_d.ent[k] = work[i];
                k = k + 1;
            end
        end
        if (take && (|acc_vld) && (k < DEPTH)) begin
            state_d.ent[k] = fresh;
            k = k + 1;
        end
        state_d.cnt = CNT_W'(k);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/rvb_checker.sv
module rvb_checker #(
    parameter int TAG_W  = 20,
    parameter int BLK_N  = 16,
    parameter int WAY_W  = 4,
    parameter int BIDX_W = 4,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_ready,
    input logic              evq_valid,
    input logic              evq_ack,
    input logic [TAG_W-1:0]  evq_tag,
    input logic [BIDX_W-1:0] evq_blk,
    input logic [WAY_W-1:0]  evq_way,
    input logic              cancel_valid,
    input logic              probe_hit,
    input logic [BLK_N-1:0]  probe_vld,
    input logic [CNT_W-1:0]  occ
);
    // R3: an offer refused for lack of space never raises occupancy
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_ready) |=> (occ <= $past(occ)));

    // R4: a full buffer always has something to drain
    assert_full_drains_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_ready |-> evq_valid);

    // R5: an unacknowledged request holds still
    assert_req_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evq_valid && !evq_ack && !cancel_valid) |=>
        (evq_valid && $stable(evq_tag) && $stable(evq_blk) && $stable(evq_way)));

    // R6: an acknowledged block is not offered again
    assert_ack_advances_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (evq_valid && evq_ack) |=>
        !(evq_valid && evq_tag == $past(evq_tag) && evq_blk == $past(evq_blk)));

    // R8: a probe miss reports no flags
    assert_miss_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !probe_hit |-> (probe_vld == '0));
endmodule

bind region_victim_buf rvb_checker #(
    .TAG_W(TAG_W), .BLK_N(BLK_N), .WAY_W(WAY_W), .BIDX_W(BIDX_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .evq_valid(evq_valid), .evq_ack(evq_ack), .evq_tag(evq_tag),
    .evq_blk(evq_blk), .evq_way(evq_way), .cancel_valid(cancel_valid),
    .probe_hit(probe_hit), .probe_vld(probe_vld), .occ(occ_q)
);

// File: tb/region_victim_buf_tb.sv
module region_victim_buf_tb;
    localparam int DEPTH = 12, BLK_N = 16, WAY_W = 4, TAG_W = 20, BIDX_W = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic acc_valid = 1'b0, evq_ack = 1'b0, cancel_valid = 1'b0;
    logic [TAG_W-1:0] acc_tag = '0, probe_tag = '0, cancel_tag = '0;
    logic [BLK_N-1:0] acc_vld = '0;
    logic [BLK_N*WAY_W-1:0] acc_way = '0;
    logic [BIDX_W-1:0] cancel_blk = '0;
    logic acc_ready, evq_valid, probe_hit;
    logic [TAG_W-1:0] evq_tag;
    logic [BIDX_W-1:0] evq_blk;
    logic [WAY_W-1:0] evq_way;
    logic [BLK_N-1:0] probe_vld;

    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    region_victim_buf u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
        .acc_tag(acc_tag), .acc_vld(acc_vld), .acc_way(acc_way),
        .evq_valid(evq_valid), .evq_ack(evq_ack), .evq_tag(evq_tag),
        .evq_blk(evq_blk), .evq_way(evq_way), .probe_tag(probe_tag),
        .probe_hit(probe_hit), .probe_vld(probe_vld), .cancel_valid(cancel_valid),
        .cancel_tag(cancel_tag), .cancel_blk(cancel_blk)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic offer(input logic [TAG_W-1:0] t, input logic [BLK_N-1:0] v,
                         input logic [BLK_N*WAY_W-1:0] w);
        @(negedge clk);
        acc_valid = 1'b1; acc_tag = t; acc_vld = v; acc_way = w;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic ack_one();
        @(negedge clk); evq_ack = 1'b1;
        @(negedge clk); evq_ack = 1'b0;
    endtask

    task automatic cancel_one(input logic [TAG_W-1:0] t, input logic [BIDX_W-1:0] b);
        @(negedge clk); cancel_valid = 1'b1; cancel_tag = t; cancel_blk = b;
        @(negedge clk); cancel_valid = 1'b0;
    endtask

    task automatic probe(input logic [TAG_W-1:0] t, input string req,
                         input logic exp_hit, input logic [BLK_N-1:0] exp_vld);
        probe_tag = t; #1;
        check({req, " hit"}, 32'(probe_hit), 32'(exp_hit));
        check({req, " vld"}, 32'(probe_vld), 32'(exp_vld));
    endtask

    task automatic expect_req(input string req, input logic [TAG_W-1:0] t,
                              input int b, input int w);
        check({req, " valid"}, 32'(evq_valid), 32'd1);
        check({req, " tag"}, 32'(evq_tag), 32'(t));
        check({req, " blk"}, 32'(evq_blk), 32'(b));
        check({req, " way"}, 32'(evq_way), 32'(w));
    endtask

    function automatic logic [BLK_N*WAY_W-1:0] way_at(input int b, input int w,
                                                      input logic [BLK_N*WAY_W-1:0] base);
        logic [BLK_N*WAY_W-1:0] r = base;
        r[b*WAY_W +: WAY_W] = WAY_W'(w);
        return r;
    endfunction

    task automatic t_reset();
        @(negedge clk);
        check("R1 ready", 32'(acc_ready), 32'd1);
        check("R1 evq_valid", 32'(evq_valid), 32'd0);
        probe(20'h00000, "R1", 1'b0, '0);
    endtask

    task automatic t_single();
        logic [BLK_N*WAY_W-1:0] w = way_at(4, 9, way_at(1, 5, '0));
        offer(20'h00111, 16'h0012, w);
        probe(20'h00111, "R2", 1'b1, 16'h0012);
        probe(20'h00999, "R8", 1'b0, '0);
        expect_req("R4", 20'h00111, 1, 5);
        repeat (3) @(negedge clk);
        expect_req("R5", 20'h00111, 1, 5);
        ack_one();
        expect_req("R6", 20'h00111, 4, 9);
        probe(20'h00111, "R6", 1'b1, 16'h0010);
        ack_one();
        check("R7 empty", 32'(evq_valid), 32'd0);
        probe(20'h00111, "R7", 1'b0, '0);
    endtask

    task automatic t_order();
        offer(20'h00B0B, 16'h0001, way_at(0, 1, '0));
        offer(20'h00C0C, 16'h8000, way_at(15, 14, '0));
        expect_req("R4 oldest", 20'h00B0B, 0, 1);
        ack_one();
        expect_req("R7 next", 20'h00C0C, 15, 14);
        ack_one();
        check("R7 drained", 32'(evq_valid), 32'd0);
    endtask

    task automatic t_full();
        for (int i = 0; i < DEPTH; i++) offer(20'h00200 + 20'(i), 16'h0001, way_at(0, i, '0));
        check("R3 full", 32'(acc_ready), 32'd0);
        offer(20'h003FF, 16'h0001, '0);
        probe(20'h003FF, "R3 refused", 1'b0, '0);
        expect_req("R4 full head", 20'h00200, 0, 0);
        ack_one();
        check("R7 space", 32'(acc_ready), 32'd1);
        for (int i = 1; i < DEPTH; i++) begin
            expect_req("R7 order", 20'h00200 + 20'(i), 0, i);
            ack_one();
        end
        check("R7 all freed", 32'(evq_valid), 32'd0);
    endtask

    task automatic t_cancel();
        logic [BLK_N*WAY_W-1:0] w = way_at(2, 7, way_at(1, 6, way_at(0, 3, '0)));
        offer(20'h00D0D, 16'h0007, w);
        cancel_one(20'h00D0D, 4'd0);
        expect_req("R9 skip", 20'h00D0D, 1, 6);
        cancel_one(20'h00D0D, 4'd2);
        probe(20'h00D0D, "R9", 1'b1, 16'h0002);
        ack_one();
        check("R9 done", 32'(evq_valid), 32'd0);
        offer(20'h00E0E, 16'h0001, '0);
        offer(20'h00F0F, 16'h0001, way_at(0, 2, '0));
        cancel_one(20'h00E0E, 4'd0);
        expect_req("R9 release", 20'h00F0F, 0, 2);
        probe(20'h00E0E, "R9 gone", 1'b0, '0);
        ack_one();
    endtask

    task automatic t_zero();
        offer(20'h00A0A, 16'h0000, '0);
        probe(20'h00A0A, "R10", 1'b0, '0);
        check("R10 evq", 32'(evq_valid), 32'd0);
        check("R10 ready", 32'(acc_ready), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_order();
        t_full();
        t_cancel();
        t_zero();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule